// File: doc/BRIEF.md
# Sized Load/Store Data Aligner

This block sits between a 64-bit integer register file and a byte-addressed, little-endian memory port that is one 64-bit word wide. Each request carries a base value, an offset and an access size. The offset is either a 13-bit signed immediate or a full register value. The block adds them to form the byte address. It then drives the read or write strobe, the byte enables and the write data, shifted into the lanes that the address selects.

When the read data for a load comes back, the block picks the addressed bytes out of the word. It extends them to 64 bits, filling with zeros or with copies of the sign bit as the request asked, and presents the result in the same cycle that the memory marks its data valid. Narrow stores keep only the low bytes of the register and raise no error for the bits they drop. An access whose address is not a multiple of its size is refused: the fault output rises and neither strobe is driven.

Top module: `lsaAligner`

## Requirements
- R1: While `reqValid` is high, `memAddr` equals `baseVal` plus the 13-bit `immOff` sign-extended when `useImm` is 1, or `baseVal` plus `regOff` when `useImm` is 0. The sum wraps modulo 2^64.
- R2: `reqSize` encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. For an accepted access, `memByteEn` is a run of (1 << `reqSize`) ones shifted left by `memAddr[2:0]`, where bit k enables byte lane k.
- R3: On an accepted store, byte lane (`memAddr[2:0]` + j) of `memWdata` carries byte j of `storeVal` for each enabled j. Store values wider than the access are silently truncated: the fault output stays 0.
- R4: When the low `reqSize` bits of the address are not all zero, `misalignFault` is 1, `memRead` and `memWrite` are 0, and `memByteEn` is 0.
- R5: `memRead` is 1 only for an aligned load (`reqStore` = 0), and `memWrite` is 1 only for an aligned store (`reqStore` = 1). Both strobes and `misalignFault` are 0 while `reqValid` is low.
- R6: Byte order is little endian: the memory byte at the access address appears in `loadData[7:0]`, and higher addresses fill higher bytes.
- R7: A load with `reqSigned` = 0 and a width under 8 bytes fills the bits of `loadData` above the access width with zeros.
- R8: A load with `reqSigned` = 1 and a width under 8 bytes fills the bits above the access width with the top bit of the loaded value. An 8-byte load returns the whole selected word either way.
- R9: `loadValid` rises in the same cycle as `memRvalid` when a load is outstanding, and `loadData` is valid in that cycle. A `memRvalid` pulse with no load outstanding produces no `loadValid`.
- R10: After reset, no load is outstanding and `loadValid`, `memRead` and `memWrite` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | Log2 of the access width in bytes |
| reqSigned | input | 1 | Sign-extend a narrow load |
| useImm | input | 1 | Take the offset from `immOff` instead of `regOff` |
| immOff | input | 13 | Signed immediate offset |
| baseVal | input | 64 | Base register value |
| regOff | input | 64 | Register offset value |
| storeVal | input | 64 | Register value to store |
| memAddr | output | 64 | Byte address of the access |
| memRead | output | 1 | Read strobe |
| memWrite | output | 1 | Write strobe |
| memByteEn | output | 8 | Byte-lane enables |
| memWdata | output | 64 | Write data, shifted into its lanes |
| memRdata | input | 64 | Read word from memory |
| memRvalid | input | 1 | Read word is valid |
| loadData | output | 64 | Extended load result |
| loadValid | output | 1 | `loadData` is valid |
| misalignFault | output | 1 | The access was refused for misalignment |

## Verification
The bench reads the same word with a set byte 7 and a set byte 3 at several widths and lanes. A design that mixed up sign and zero filling, or selected lanes big-endian, would return a visibly wrong upper half. It stores values wider than the access and checks that the enables and data lanes match the address and that no fault is raised; a design that shifted by bytes instead of bits would put data in the wrong lane. It issues misaligned half-word and word accesses, where a leaky design would still strobe memory. It also sends a stray read-valid pulse with no load outstanding, which a design that does not track the outstanding load would forward as a load result.

// File: rtl/lsaPkg.sv
package lsaPkg;
  // width code carried on reqSize
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rdEn;
    logic wrEn;
  } lsaStrobe_t;
endpackage

// File: rtl/lsaCtrl.sv
module lsaCtrl
  import lsaPkg::*;
#(
  parameter int LANE_W = 3,
  parameter int SZ_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [SZ_W-1:0]   reqSize,
  input  logic [LANE_W-1:0] lane,
  input  logic              memRvalid,
  output lsaStrobe_t        strb,
  output logic              misalignFault,
  output logic              loadValid
);
  logic [LANE_W-1:0] alignMask;
  logic              misaligned;
  logic              loadPending;

  // low-bit mask of the access size: bit b set when b < size code
  always_comb begin
    for (int b = 0; b < LANE_W; b++) begin
      alignMask[b] = (b < int'(reqSize));
    end
  end

  assign misaligned    = |(lane & alignMask);
  assign misalignFault = reqValid & misaligned;
  assign strb.rdEn     = reqValid & ~misaligned & ~reqStore;
  assign strb.wrEn     = reqValid & ~misaligned & reqStore;
  assign loadValid     = memRvalid & loadPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadPending <= 1'b0;
    end else if (strb.rdEn) begin
      loadPending <= 1'b1;
    end else if (memRvalid) begin
      loadPending <= 1'b0;
    end
  end
endmodule

// File: rtl/lsaDatapath.sv
module lsaDatapath
  import lsaPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 13,
  parameter int BYTES  = DATA_W / 8,
  parameter int LANE_W = $clog2(BYTES),
  parameter int SZ_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsaStrobe_t        strb,
  input  logic [SZ_W-1:0]   reqSize,
  input  logic              reqSigned,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  immOff,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DATA_W-1:0] regOff,
  input  logic [DATA_W-1:0] storeVal,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [BYTES-1:0]  memByteEn,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] loadData,
  output logic [LANE_W-1:0] lane
);
  logic [DATA_W-1:0] offset;
  logic [BYTES-1:0]  sizeMask;
  logic [LANE_W-1:0] capLane;
  logic [SZ_W-1:0]   capSize;
  logic              capSigned;
  logic [DATA_W-1:0] rdShifted;

  // effective address
  assign offset  = useImm ? {{(DATA_W-IMM_W){immOff[IMM_W-1]}}, immOff} : regOff;
  assign memAddr = baseVal + offset;
  assign lane    = memAddr[LANE_W-1:0];

  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      sizeMask[b] = (b < (1 << int'(reqSize)));
    end
  end

  assign memByteEn = (strb.rdEn | strb.wrEn) ? (sizeMask << lane) : '0;
  assign memWdata  = storeVal << {lane, 3'b000};

  // lane, width and signedness of the outstanding load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capLane   <= '0;
      capSize   <= '0;
      capSigned <= 1'b0;
    end else if (strb.rdEn) begin
      capLane   <= lane;
      capSize   <= reqSize;
      capSigned <= reqSigned;
    end
  end

  assign rdShifted = memRdata >> {capLane, 3'b000};

  // extend the selected bytes; one branch per width code
  always_comb begin
    loadData = rdShifted;
    for (int k = 0; k <= LANE_W; k++) begin
      if (int'(capSize) == k) begin
        for (int b = 0; b < DATA_W; b++) begin
          loadData[b] = (b < (8 << k)) ? rdShifted[b]
                                       : (capSigned & rdShifted[(8 << k) - 1]);
        end
      end
    end
  end
endmodule

// File: rtl/lsaAligner.sv
module lsaAligner
  import lsaPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 13,
  parameter int BYTES  = DATA_W / 8,
  parameter int LANE_W = $clog2(BYTES),
  parameter int SZ_W   = $clog2(LANE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [SZ_W-1:0]   reqSize,
  input  logic              reqSigned,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  immOff,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DATA_W-1:0] regOff,
  input  logic [DATA_W-1:0] storeVal,
  output logic [DATA_W-1:0] memAddr,
  output logic              memRead,
  output logic              memWrite,
  output logic [BYTES-1:0]  memByteEn,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memRvalid,
  output logic [DATA_W-1:0] loadData,
  output logic              loadValid,
  output logic              misalignFault
);
  lsaStrobe_t        strb;
  logic [LANE_W-1:0] lane;

  lsaCtrl #(.LANE_W(LANE_W), .SZ_W(SZ_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqSize(reqSize), .lane(lane), .memRvalid(memRvalid), .strb(strb),
    .misalignFault(misalignFault), .loadValid(loadValid)
  );

  lsaDatapath #(.DATA_W(DATA_W), .IMM_W(IMM_W), .BYTES(BYTES),
                .LANE_W(LANE_W), .SZ_W(SZ_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqSize(reqSize),
    .reqSigned(reqSigned), .useImm(useImm), .immOff(immOff),
    .baseVal(baseVal), .regOff(regOff), .storeVal(storeVal),
    .memRdata(memRdata), .memAddr(memAddr), .memByteEn(memByteEn),
    .memWdata(memWdata), .loadData(loadData), .lane(lane)
  );

  assign memRead  = strb.rdEn;
  assign memWrite = strb.wrEn;
endmodule

// File: rtl/lsaAlignerChk.sv
module lsaAlignerChk #(
  parameter int DATA_W = 64,
  parameter int BYTES  = DATA_W / 8,
  parameter int LANE_W = $clog2(BYTES),
  parameter int SZ_W   = $clog2(LANE_W + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [SZ_W-1:0]   reqSize,
  input logic              reqSigned,
  input logic [DATA_W-1:0] memAddr,
  input logic              memRead,
  input logic              memWrite,
  input logic [BYTES-1:0]  memByteEn,
  input logic              memRvalid,
  input logic [DATA_W-1:0] loadData,
  input logic              loadValid,
  input logic              misalignFault
);
  logic [SZ_W-1:0] chkSize;
  logic            chkSigned;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkSize   <= '0;
      chkSigned <= 1'b0;
    end else if (memRead) begin
      chkSize   <= reqSize;
      chkSigned <= reqSigned;
    end
  end

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!memRead && !memWrite && !misalignFault)); // R5
  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    misalignFault |-> (!memRead && !memWrite && memByteEn == '0)); // R4
  AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (memRead || memWrite) |-> ($countones(memByteEn) == (1 << int'(reqSize)))); // R2
  AST_BE_ANCHOR: assert property (@(posedge clk) disable iff (!rstN)
    (memRead || memWrite) |-> memByteEn[memAddr[LANE_W-1:0]]); // R2
  AST_LOAD_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> memRvalid); // R9
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && !chkSigned && chkSize == '0) |-> (loadData[DATA_W-1:8] == '0)); // R7
  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && chkSigned && chkSize == SZ_W'(1))
      |-> (loadData[DATA_W-1:16] == {(DATA_W-16){loadData[15]}})); // R8
endmodule

bind lsaAligner lsaAlignerChk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/lsaAligner_tb_top.sv
`timescale 1ns/1ps
module lsaAligner_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqStore = 1'b0, reqSigned = 1'b0, useImm = 1'b0;
  logic [1:0]  reqSize = '0;
  logic [12:0] immOff = '0;
  logic [63:0] baseVal = '0, regOff = '0, storeVal = '0, memRdata = '0;
  logic        memRvalid = 1'b0;
  logic [63:0] memAddr, memWdata, loadData;
  logic        memRead, memWrite, loadValid, misalignFault;
  logic [7:0]  memByteEn;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lsaAligner dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqSize(reqSize), .reqSigned(reqSigned), .useImm(useImm), .immOff(immOff),
    .baseVal(baseVal), .regOff(regOff), .storeVal(storeVal), .memAddr(memAddr),
    .memRead(memRead), .memWrite(memWrite), .memByteEn(memByteEn),
    .memWdata(memWdata), .memRdata(memRdata), .memRvalid(memRvalid),
    .loadData(loadData), .loadValid(loadValid), .misalignFault(misalignFault)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tReset();
    memRvalid = 1'b1;
    #1;
    chk("R10 loadValid after reset", 64'(loadValid), 64'd0);
    chk("R10 strobes after reset", {62'd0, memRead, memWrite}, 64'd0);
    memRvalid = 1'b0;
  endtask

  task automatic tAddr();
    @(negedge clk);
    reqValid = 1'b1; reqStore = 1'b1; reqSize = 2'd3; useImm = 1'b1;
    baseVal = 64'h1000; immOff = 13'h1FF8;
    #1;
    chk("R1 immediate -8", memAddr, 64'h0FF8);
    chk("R5 aligned store strobe", {62'd0, memRead, memWrite}, 64'd1);
    useImm = 1'b0; baseVal = 64'h10; regOff = 64'hFFFF_FFFF_FFFF_FFF0;
    #1;
    chk("R1 register offset wrap", memAddr, 64'h0);
    useImm = 1'b1; baseVal = 64'h0; immOff = 13'h0FFF;
    #1;
    chk("R1 immediate max", memAddr, 64'h0FFF);
    reqValid = 1'b0;
    #1;
    chk("R5 idle quiet", {61'd0, memRead, memWrite, misalignFault}, 64'd0);
  endtask

  task automatic tStore(input logic [63:0] addr, input logic [1:0] sz,
                        input logic [63:0] val, input logic [7:0] expBe);
    logic [63:0] expW;
    logic [63:0] laneMask;
    int n;
    n = 1 << sz;
    expW = '0;
    laneMask = '0;
    for (int j = 0; j < n; j++) begin
      expW[(int'(addr[2:0]) + j) * 8 +: 8] = val[j*8 +: 8];
      laneMask[(int'(addr[2:0]) + j) * 8 +: 8] = 8'hFF;
    end
    @(negedge clk);
    reqValid = 1'b1; reqStore = 1'b1; reqSize = sz; useImm = 1'b0;
    baseVal = addr; regOff = '0; storeVal = val;
    #1;
    chk("R2 byte enables", 64'(memByteEn), 64'(expBe));
    chk("R3 write lanes", memWdata & laneMask, expW);
    chk("R3 no fault on truncation", {62'd0, misalignFault, memWrite}, 64'd1);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic tMisalign(input logic store, input logic [1:0] sz, input logic [63:0] addr);
    @(negedge clk);
    reqValid = 1'b1; reqStore = store; reqSize = sz; useImm = 1'b0;
    baseVal = addr; regOff = '0;
    #1;
    chk("R4 fault raised", 64'(misalignFault), 64'd1);
    chk("R4 no strobe, no enables", {54'd0, memRead, memWrite, memByteEn}, 64'd0);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic tLoad(input string req, input logic [63:0] addr, input logic [1:0] sz,
                       input logic sgn, input logic [63:0] exp);
    @(negedge clk);
    reqValid = 1'b1; reqStore = 1'b0; reqSize = sz; reqSigned = sgn;
    useImm = 1'b0; baseVal = addr; regOff = '0;
    #1;
    chk("R5 load strobe", {62'd0, memRead, memWrite}, 64'd2);
    @(negedge clk);
    reqValid = 1'b0;
    memRdata = 64'h80FF_7F01_8C3D_A5E6;
    memRvalid = 1'b1;
    #1;
    chk("R9 loadValid with rvalid", 64'(loadValid), 64'd1);
    chk(req, loadData, exp);
    @(negedge clk);
    memRvalid = 1'b0;
    #1;
    chk("R9 loadValid drops", 64'(loadValid), 64'd0);
  endtask

  task automatic tStray();
    @(negedge clk);
    memRvalid = 1'b1;
    #1;
    chk("R9 stray rvalid ignored", 64'(loadValid), 64'd0);
    @(negedge clk);
    memRvalid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tReset();
    rstN = 1'b1;
    tAddr();
    tStore(64'h105, 2'd0, 64'h1234_5678_9ABC_DEAB, 8'h20);
    tStore(64'h206, 2'd1, 64'hFFFF_0000_1111_C0DE, 8'hC0);
    tStore(64'h304, 2'd2, 64'hAAAA_BBBB_0102_0304, 8'hF0);
    tStore(64'h400, 2'd3, 64'h0011_2233_4455_6677, 8'hFF);
    tMisalign(1'b1, 2'd2, 64'h502);
    tMisalign(1'b0, 2'd1, 64'h603);
    tLoad("R6 R7 byte 7 unsigned", 64'h7, 2'd0, 1'b0, 64'h80);
    tLoad("R8 byte 7 signed", 64'h7, 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FF80);
    tLoad("R7 half lane 2 unsigned", 64'h2, 2'd1, 1'b0, 64'h8C3D);
    tLoad("R8 half lane 2 signed", 64'h2, 2'd1, 1'b1, 64'hFFFF_FFFF_FFFF_8C3D);
    tLoad("R8 word lane 4 signed", 64'h4, 2'd2, 1'b1, 64'hFFFF_FFFF_80FF_7F01);
    tLoad("R7 word lane 0 unsigned", 64'h0, 2'd2, 1'b0, 64'h8C3D_A5E6);
    tLoad("R6 byte 4 signed positive", 64'h4, 2'd0, 1'b1, 64'h01);
    tLoad("R8 full word signed", 64'h8, 2'd3, 1'b1, 64'h80FF_7F01_8C3D_A5E6);
    tStray();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule